// File: doc/BRIEF.md
# Single-Cycle Glitch Detector

This block watches a bus that is sampled on a single clock and flags any bit that holds a value for exactly one sample while the samples on both sides agree. Such a bit is a lone high spike inside a low level, or a lone low dip inside a high level. Every raw bit first passes through a two-flop synchronizer. It then enters a three-deep history of consecutive samples, and a combinational decode of that history raises a per-bit trigger. Ordinary edges never trigger, and neither do levels that last two samples or more. The target sampling clock is 60 MHz.

The per-bit triggers feed three things. The first is a registered OR, a clean one-cycle pulse meant for a scope test pin. The second is a set of sticky per-bit flags, which software-free debug logic can inspect and clear with a strobe. The third is a saturating event counter. Triggers stay suppressed after reset until the history holds three samples taken since reset was released.

Top module: `spike_watch`

## Requirements
- R1: Each input bit passes through two synchronizer flops and then a three-stage history (newest, middle, oldest). A value applied before clock edge k reaches the newest history slot after edge k+2, counting from edge k as the first of three edges.
- R2: A bit's trigger output is high, with no register after the history, whenever its history reads newest/middle/oldest = 1,0,1 or 0,1,0. So a one-sample spike of either polarity is reported while it sits in the middle slot.
- R3: A bit whose value stays equal for two or more consecutive samples, including a plain edge from one level to another, never raises its trigger.
- R4: After reset is released, all triggers stay low until three history loads have taken place. This holds even if the synchronized input was toggling during reset.
- R5: The combined trigger is high in the cycle after any per-bit trigger was high and low in the cycle after all were low. It is a registered OR.
- R6: A bit's sticky flag is set in the cycle after its trigger is high and stays set until reset or the clear strobe. Clear is registered. If a trigger on a bit and the clear strobe occur in the same cycle, that bit's flag ends up set.
- R7: The event counter is 16 bits wide. It adds one for each cycle in which at least one trigger is high, however many bits fired, and it holds at 65535 once reached. The clear strobe does not affect it.
- R8: Synchronous active-high reset zeroes the history, the combined trigger, the sticky flags and the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | WIDTH | Raw monitored bus |
| clr_flags | input | 1 | Strobe that clears the sticky flags |
| bit_trig | output | WIDTH | Per-bit combinational trigger |
| any_trig | output | 1 | Registered OR of all per-bit triggers |
| flags | output | WIDTH | Sticky per-bit flags |
| event_cnt | output | CNT_W | Saturating count of trigger cycles |

## Verification
The bench drives two-sample pulses and plain edges next to true one-sample spikes of both polarities. A decoder that looked at only two samples would fire on those two-sample pulses and edges. It holds a bus in continuous toggling while reset is released. A design without fill gating would then report phantom spikes built from reset-time history. It asserts clear in a cycle where every bit is firing, which catches a clear-over-set priority that drops an event. It drives more than 65535 trigger cycles, which catches a counter that wraps to zero instead of holding.

// File: rtl/spike_pkg.sv
package spike_pkg;
    localparam int HIST_DEPTH = 3;
    localparam int FILL_W     = $clog2(HIST_DEPTH + 1);

    // newest, middle, oldest of one bit
    typedef struct packed {
        logic newest;
        logic middle;
        logic oldest;
    } bit_hist_t;

    function automatic logic is_spike(input bit_hist_t h);
        return (h.newest == h.oldest) && (h.newest != h.middle);
    endfunction
endpackage

// File: rtl/spike_sync.sv
module spike_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage [STAGES];

    always_ff @(posedge clk) stage[0] <= d_i;

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) stage[s] <= stage[s-1];
    end

    assign q_o = stage[STAGES-1];
endmodule

// File: rtl/spike_hist.sv
module spike_hist
    import spike_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] sample_i,
    output logic [WIDTH-1:0] trig_o
);
    localparam logic [FILL_W-1:0] FULL = FILL_W'(HIST_DEPTH);

    logic [WIDTH-1:0]  h_new, h_mid, h_old;
    logic [FILL_W-1:0] fill;
    logic              full;

    always_ff @(posedge clk) begin
        if (rst) begin
            h_new <= '0;
            h_mid <= '0;
            h_old <= '0;
            fill  <= '0;
        end else begin
            h_new <= sample_i;
            h_mid <= h_new;
            h_old <= h_mid;
            if (fill != FULL) fill <= fill + 1'b1;
        end
    end

    assign full = (fill == FULL);

    for (genvar b = 0; b < WIDTH; b++) begin : g_decode
        bit_hist_t hb;
        assign hb        = '{newest: h_new[b], middle: h_mid[b], oldest: h_old[b]};
        assign trig_o[b] = full & is_spike(hb);
    end

    // R1: history shifts one slot per clock
    a_r1_shift_mid: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (h_mid == $past(h_new)));
    a_r1_shift_old: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (h_old == $past(h_mid)));
    // R4: fill count only grows until full and then stays
    a_r4_fill_hold: assert property (@(posedge clk) disable iff (rst)
        full |=> full);
endmodule

// File: rtl/spike_event.sv
module spike_event #(
    parameter int WIDTH = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] trig_i,
    input  logic             clr_i,
    output logic             any_o,
    output logic [WIDTH-1:0] flag_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             any_q;
    logic [WIDTH-1:0] flag_q;
    logic [CNT_W-1:0] cnt_q;
    logic             hit;

    assign hit = |trig_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            any_q  <= 1'b0;
            flag_q <= '0;
            cnt_q  <= '0;
        end else begin
            any_q  <= hit;
            flag_q <= (clr_i ? '0 : flag_q) | trig_i;
            if (hit && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign any_o  = any_q;
    assign flag_o = flag_q;
    assign cnt_o  = cnt_q;

    a_r5_any_follows: assert property (@(posedge clk) disable iff (rst)
        (trig_i != '0) |=> any_o);
    a_r5_any_quiet: assert property (@(posedge clk) disable iff (rst)
        (trig_i == '0) |=> !any_o);
    a_r6_flag_sets: assert property (@(posedge clk) disable iff (rst)
        (trig_i != '0) |=> ((flag_o & $past(trig_i)) == $past(trig_i)));
    a_r6_flag_holds: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> ((flag_o & $past(flag_o)) == $past(flag_o)));
    a_r7_cnt_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + 1'b1));
    a_r7_cnt_sat: assert property (@(posedge clk) disable iff (rst)
        (cnt_o == CNT_MAX) |=> (cnt_o == CNT_MAX));
endmodule

// File: rtl/spike_watch.sv
module spike_watch #(
    parameter int WIDTH       = 8,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] data_in,
    input  logic             clr_flags,
    output logic [WIDTH-1:0] bit_trig,
    output logic             any_trig,
    output logic [WIDTH-1:0] flags,
    output logic [CNT_W-1:0] event_cnt
);
    logic [WIDTH-1:0] synced;

    spike_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d_i (data_in),
        .q_o (synced)
    );

    spike_hist #(.WIDTH(WIDTH)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .sample_i (synced),
        .trig_o   (bit_trig)
    );

    spike_event #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_event (
        .clk    (clk),
        .rst    (rst),
        .trig_i (bit_trig),
        .clr_i  (clr_flags),
        .any_o  (any_trig),
        .flag_o (flags),
        .cnt_o  (event_cnt)
    );
endmodule

// File: tb/spike_watch_bench.sv
module spike_watch_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W   = 8;
    localparam int CW  = 16;
    localparam logic [CW-1:0] MAXC = '1;
    localparam int NVEC = 40;

    // entry = {clear strobe, data}
    localparam logic [W:0] VEC [NVEC] = '{
        9'h000, 9'h000, 9'h000, 9'h001, 9'h000, 9'h000,
        9'h003, 9'h003, 9'h000, 9'h000, 9'h000,
        9'h0F0, 9'h0F0, 9'h0F0, 9'h070, 9'h0F0, 9'h0F0,
        9'h024, 9'h000, 9'h024, 9'h000, 9'h000, 9'h000,
        9'h100, 9'h000, 9'h000,
        9'h0AA, 9'h055, 9'h0AA, 9'h055, 9'h0AA, 9'h055, 9'h1AA,
        9'h055, 9'h0AA, 9'h0AA, 9'h0AA, 9'h0AA, 9'h0FF, 9'h0FF
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  data_in = '0;
    logic          clr_flags = 1'b0;
    logic [W-1:0]  bit_trig, flags;
    logic          any_trig;
    logic [CW-1:0] event_cnt;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model
    logic [W-1:0]  vh [5] = '{default: '0};
    logic [W-1:0]  prev_pulse = '0;
    logic          prev_c = 1'b0;
    logic          prev_r = 1'b1;
    int            loads = 0;
    logic          m_any = 1'b0;
    logic [W-1:0]  m_flag = '0;
    logic [CW-1:0] m_cnt = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spike_watch u_spike_watch (
        .clk       (clk),
        .rst       (rst),
        .data_in   (data_in),
        .clr_flags (clr_flags),
        .bit_trig  (bit_trig),
        .any_trig  (any_trig),
        .flags     (flags),
        .event_cnt (event_cnt)
    );

    function automatic logic [W-1:0] spikes(input logic [W-1:0] n, input logic [W-1:0] m,
                                            input logic [W-1:0] o);
        logic [W-1:0] r;
        for (int b = 0; b < W; b++) r[b] = (n[b] == o[b]) && (n[b] != m[b]);
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic [W-1:0] d, input logic c, input logic r);
        logic [W-1:0] exp_pulse;
        @(negedge clk);
        if (prev_r) begin
            loads  = 0;
            m_any  = 1'b0;
            m_flag = '0;
            m_cnt  = '0;
        end else begin
            if (loads < 3) loads++;
            m_any  = |prev_pulse;
            m_flag = prev_c ? prev_pulse : (m_flag | prev_pulse);
            if ((|prev_pulse) && m_cnt != MAXC) m_cnt = m_cnt + 1'b1;
        end
        exp_pulse = (loads >= 3) ? spikes(vh[2], vh[3], vh[4]) : '0;
        if (loads < 3) check("R4 trigger during fill", 32'(bit_trig), 32'(exp_pulse));
        else           check("R1/R2/R3 bit trigger", 32'(bit_trig), 32'(exp_pulse));
        check("R5 combined trigger", 32'(any_trig), 32'(m_any));
        check("R6 sticky flags", 32'(flags), 32'(m_flag));
        check("R7 event counter", 32'(event_cnt), 32'(m_cnt));
        data_in   = d;
        clr_flags = c;
        rst       = r;
        for (int k = 4; k > 0; k--) vh[k] = vh[k-1];
        vh[0]      = d;
        prev_pulse = exp_pulse;
        prev_c     = c;
        prev_r     = r;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // reset phase
        for (int i = 0; i < 6; i++) step('0, 1'b0, 1'b1);
        // R8: reset state after a clean reset
        check("R8 reset any", 32'(any_trig), 32'd0);
        check("R8 reset flags", 32'(flags), 32'd0);
        check("R8 reset count", 32'(event_cnt), 32'd0);
        step('0, 1'b0, 1'b0);

        // vector table walk
        for (int i = 0; i < NVEC; i++) step(VEC[i][W-1:0], VEC[i][W], 1'b0);
        for (int i = 0; i < 6; i++) step('0, 1'b0, 1'b0);

        // R4: toggling through reset and its release
        for (int i = 0; i < 4; i++) step((i % 2) ? 8'h0F : 8'hF0, 1'b0, 1'b1);
        for (int i = 0; i < 8; i++) step((i % 2) ? 8'h0F : 8'hF0, 1'b0, 1'b0);
        for (int i = 0; i < 6; i++) step('0, 1'b0, 1'b0);

        // R7: drive well past saturation with a toggling bit
        for (int i = 0; i < 65545; i++) step((i % 2) ? 8'h01 : 8'h00, 1'b0, 1'b0);
        check("R7 saturated count", 32'(event_cnt), 32'(MAXC));
        // R6: clear while bit 0 is firing; flag must stay set
        step(8'h00, 1'b1, 1'b0);
        step(8'h01, 1'b0, 1'b0);
        check("R6 clear/trigger collision", 32'(flags[0]), 32'd1);
        check("R7 clear leaves count", 32'(event_cnt), 32'(MAXC));
        // R3: steady level, no more triggers once history settles
        for (int i = 0; i < 8; i++) step(8'h01, 1'b0, 1'b0);
        check("R3 steady level quiet", 32'(bit_trig), 32'd0);
        step(8'h01, 1'b1, 1'b0);
        step(8'h01, 1'b0, 1'b0);
        check("R6 clear with no trigger", 32'(flags), 32'd0);

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule